// File: doc/BRIEF.md
# Low-Frequency Prescaled Real-Time Counter

This block keeps time from a slow reference clock. A 15-bit pre-counter advances on every active clock cycle, and a 32-bit main counter advances on selected cycles. The main counter can tick from a power-of-two divider whose ratio runs from 1 to 32768. In the other mode it ticks when the pre-counter equals a programmable match value. Each counter can be told to wrap at a programmable top value instead of at its full width. Software can load either counter directly.

Counting is controlled by a two-state machine, `ST_IDLE` and `ST_RUN`. The transition `ST_IDLE -> ST_RUN` fires on a start strobe when no stop strobe is present. The transition `ST_RUN -> ST_IDLE` fires on a stop strobe. In every other case the state holds. The counters move only in `ST_RUN`, and only while the enable input is high. They also stop while the debug-halt input is asserted, unless debug running is allowed. A combined 32-bit snapshot word packs the pre-counter together with the low main-counter bits, so that one read returns both. One-cycle pulses mark every main-counter advance and every main-counter wrap.

Top module: `lf_rtc_counter`

## Requirements
- R1: After reset both counters are zero, `running_o` is 0, and `tick_o` and `ovf_o` are 0.
- R2: A start strobe moves the block to running on the next edge, and a stop strobe moves it to stopped. If both strobes arrive in the same cycle, stop wins. `running_o` shows the state.
- R3: The pre-counter increases by one on each edge where the block is running, `enable_i` is 1 and the block is not debug-frozen. Otherwise it holds. With its top disabled, it wraps from 0x7FFF to 0.
- R4: While `dbg_halt_i` is 1 and `dbg_run_i` is 0, neither counter changes except by a software write. With `dbg_run_i` set to 1, the debug-halt input has no effect.
- R5: With `tick_mode_i`=0, the main counter ticks on active cycles in which the low k bits of the pre-counter are all ones, where k = `psc_sel_i` (0..15). With the pre-counter top disabled, this is one tick every 2^k active cycles.
- R6: With `tick_mode_i`=1, the main counter ticks on active cycles in which the pre-counter equals `cmp0_i`.
- R7: With `pre_top_en_i`=1, a pre-counter equal to `cmp0_i` goes to 0 on its next advance.
- R8: With `main_top_en_i`=1, a tick when the main counter equals `cmp1_i` loads 0 and raises `ovf_o`.
- R9: A tick at 0xFFFFFFFF loads 0 and raises `ovf_o`.
- R10: `tick_o` is high for exactly the one cycle that follows each main-counter advance. `ovf_o` is high only together with `tick_o`.
- R11: A write strobe loads its counter on the next edge and overrides that cycle's increment. A main-counter write also suppresses that cycle's `tick_o` and `ovf_o`.
- R12: `combo_o[14:0]` is the pre-counter and `combo_o[31:15]` is main-counter bits [16:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency counting clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| enable_i | input | 1 | Block enable |
| dbg_halt_i | input | 1 | Debugger halt request |
| dbg_run_i | input | 1 | 1: keep counting while halted |
| tick_mode_i | input | 1 | 0: divider ticks, 1: pre-counter match ticks |
| psc_sel_i | input | 4 | Divider exponent k |
| pre_top_en_i | input | 1 | Pre-counter wraps at `cmp0_i` |
| main_top_en_i | input | 1 | Main counter wraps at `cmp1_i` |
| cmp0_i | input | 15 | Pre-counter match / top value |
| cmp1_i | input | 32 | Main-counter top value |
| pre_wr_i | input | 1 | Pre-counter write strobe |
| pre_wdata_i | input | 15 | Pre-counter write value |
| main_wr_i | input | 1 | Main-counter write strobe |
| main_wdata_i | input | 32 | Main-counter write value |
| pre_cnt_o | output | 15 | Pre-counter value |
| main_cnt_o | output | 32 | Main-counter value |
| combo_o | output | 32 | Packed snapshot word |
| running_o | output | 1 | Block is in `ST_RUN` |
| tick_o | output | 1 | Main counter advanced |
| ovf_o | output | 1 | Main counter wrapped |

## Verification
Some rules are checked by the assertions on every cycle:
- stop wins over a simultaneous start;
- both counters stay frozen while debug-halted, and the main counter stays frozen while stopped;
- each `tick_o` matches a single step of the main counter;
- each `ovf_o` comes with `tick_o` and a zero count.

Other behaviour is shown only by the bench scenarios:
- the divide-by-2^k rate;
- ticks from pre-counter matches;
- wrap points at the programmed top values;
- the packing of the snapshot word;
- write priority over increments.

In those scenarios, a cycle-accurate reference model is compared against every output on every cycle.

// File: rtl/lf_rtc_pkg.sv
package lf_rtc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/lf_rtc_ctrl.sv
module lf_rtc_ctrl
    import lf_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic enable_i,
    input  logic dbg_halt_i,
    input  logic dbg_run_i,
    output logic running_o,
    output logic active_o
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i && !stop_i) state_d = ST_RUN;
            ST_RUN:  if (stop_i)             state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running_o = (state_q == ST_RUN);
        active_o  = running_o && enable_i && !(dbg_halt_i && !dbg_run_i);
    end
endmodule

// File: rtl/lf_rtc_precnt.sv
module lf_rtc_precnt #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         top_en_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] cnt_o,
    output logic         match_o
);
    logic [W-1:0] cnt_q;

    assign match_o = (cnt_q == top_i);
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (wr_i)               cnt_q <= wdata_i;
        else if (active_i) begin
            if (top_en_i && match_o) cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lf_rtc_maincnt.sv
module lf_rtc_maincnt #(
    parameter int PRE_W  = 15,
    parameter int MAIN_W = 32,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic [PRE_W-1:0]  pre_cnt_i,
    input  logic              pre_match_i,
    input  logic              tick_mode_i,
    input  logic [SEL_W-1:0]  psc_sel_i,
    input  logic              top_en_i,
    input  logic [MAIN_W-1:0] top_i,
    input  logic              wr_i,
    input  logic [MAIN_W-1:0] wdata_i,
    output logic [MAIN_W-1:0] cnt_o,
    output logic              tick_o,
    output logic              ovf_o
);
    logic [PRE_W-1:0]  psc_mask;
    logic [MAIN_W-1:0] cnt_q;
    logic              div_hit, adv, wrap;

    for (genvar g = 0; g < PRE_W; g++) begin : g_mask
        assign psc_mask[g] = (32'(psc_sel_i) > 32'(g));
    end

    assign div_hit = ((pre_cnt_i & psc_mask) == psc_mask);
    assign adv     = active_i && (tick_mode_i ? pre_match_i : div_hit);
    assign wrap    = (top_en_i && (cnt_q == top_i)) || (&cnt_q);
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
            ovf_o  <= 1'b0;
        end else begin
            tick_o <= adv && !wr_i;
            ovf_o  <= adv && !wr_i && wrap;
            if (wr_i)     cnt_q <= wdata_i;
            else if (adv) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lf_rtc_counter.sv
module lf_rtc_counter #(
    parameter int PRE_W   = 15,
    parameter int MAIN_W  = 32,
    parameter int SEL_W   = 4,
    parameter int COMBO_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               enable_i,
    input  logic               dbg_halt_i,
    input  logic               dbg_run_i,
    input  logic               tick_mode_i,
    input  logic [SEL_W-1:0]   psc_sel_i,
    input  logic               pre_top_en_i,
    input  logic               main_top_en_i,
    input  logic [PRE_W-1:0]   cmp0_i,
    input  logic [MAIN_W-1:0]  cmp1_i,
    input  logic               pre_wr_i,
    input  logic [PRE_W-1:0]   pre_wdata_i,
    input  logic               main_wr_i,
    input  logic [MAIN_W-1:0]  main_wdata_i,
    output logic [PRE_W-1:0]   pre_cnt_o,
    output logic [MAIN_W-1:0]  main_cnt_o,
    output logic [COMBO_W-1:0] combo_o,
    output logic               running_o,
    output logic               tick_o,
    output logic               ovf_o
);
    localparam int LOW_W = COMBO_W - PRE_W;

    logic active, pre_match;

    lf_rtc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .enable_i(enable_i), .dbg_halt_i(dbg_halt_i), .dbg_run_i(dbg_run_i),
        .running_o(running_o), .active_o(active)
    );

    lf_rtc_precnt #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .active_i(active), .wr_i(pre_wr_i),
        .wdata_i(pre_wdata_i), .top_en_i(pre_top_en_i), .top_i(cmp0_i),
        .cnt_o(pre_cnt_o), .match_o(pre_match)
    );

    lf_rtc_maincnt #(.PRE_W(PRE_W), .MAIN_W(MAIN_W), .SEL_W(SEL_W)) u_main (
        .clk(clk), .rst_n(rst_n), .active_i(active), .pre_cnt_i(pre_cnt_o),
        .pre_match_i(pre_match), .tick_mode_i(tick_mode_i), .psc_sel_i(psc_sel_i),
        .top_en_i(main_top_en_i), .top_i(cmp1_i), .wr_i(main_wr_i),
        .wdata_i(main_wdata_i), .cnt_o(main_cnt_o), .tick_o(tick_o), .ovf_o(ovf_o)
    );

    assign combo_o = {main_cnt_o[LOW_W-1:0], pre_cnt_o};
endmodule

// File: rtl/lf_rtc_counter_chk.sv
module lf_rtc_counter_chk #(
    parameter int PRE_W  = 15,
    parameter int MAIN_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              dbg_halt_i,
    input logic              dbg_run_i,
    input logic              pre_wr_i,
    input logic              main_wr_i,
    input logic [PRE_W-1:0]  pre_cnt_o,
    input logic [MAIN_W-1:0] main_cnt_o,
    input logic              running_o,
    input logic              tick_o,
    input logic              ovf_o
);
    // R2
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !running_o);

    // R2
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> running_o);

    // R4
    dbg_freeze_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt_i && !dbg_run_i && !pre_wr_i) |=> $stable(pre_cnt_o));

    // R4
    dbg_freeze_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt_i && !dbg_run_i && !main_wr_i) |=> $stable(main_cnt_o) && !tick_o);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !main_wr_i && !pre_wr_i) |=> $stable(main_cnt_o) && $stable(pre_cnt_o));

    // R10
    ovf_with_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> tick_o);

    // R10
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !ovf_o) |-> main_cnt_o == $past(main_cnt_o) + 1'b1);

    // R8
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> main_cnt_o == '0);
endmodule

bind lf_rtc_counter lf_rtc_counter_chk #(.PRE_W(PRE_W), .MAIN_W(MAIN_W)) chk_i (.*);

// File: tb/lf_rtc_counter_test.sv
`timescale 1ns/1ps
module lf_rtc_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, stop_i = 0, enable_i = 0, dbg_halt_i = 0, dbg_run_i = 0;
    logic        tick_mode_i = 0, pre_top_en_i = 0, main_top_en_i = 0;
    logic [3:0]  psc_sel_i = 0;
    logic [14:0] cmp0_i = 0, pre_wdata_i = 0;
    logic [31:0] cmp1_i = 0, main_wdata_i = 0;
    logic        pre_wr_i = 0, main_wr_i = 0;
    logic [14:0] pre_cnt_o;
    logic [31:0] main_cnt_o, combo_o;
    logic        running_o, tick_o, ovf_o;

    int total = 0;
    int bad = 0;
    logic        m_run, m_tick, m_ovf;
    logic [14:0] m_pre;
    logic [31:0] m_main;

    always #5 clk = ~clk;

    lf_rtc_counter uut (.*);

    // Reference model, written from the requirements
    function automatic logic tick_due(logic [14:0] pre);
        logic [14:0] mask = 15'((32'd1 << psc_sel_i) - 1);
        return tick_mode_i ? (pre == cmp0_i) : ((pre & mask) == mask);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pre = 0; m_main = 0; m_tick = 0; m_ovf = 0;
        end else begin
            logic act, tk, wr;
            act = m_run && enable_i && !(dbg_halt_i && !dbg_run_i);
            tk  = act && tick_due(m_pre);
            wr  = (main_wr_i) || (main_top_en_i && m_main == cmp1_i) || (m_main == 32'hFFFF_FFFF);
            m_tick = tk && !main_wr_i;
            m_ovf  = m_tick && wr;
            if (main_wr_i)   m_main = main_wdata_i;
            else if (tk)     m_main = m_ovf ? 32'd0 : m_main + 1;
            if (pre_wr_i)    m_pre = pre_wdata_i;
            else if (act)    m_pre = (pre_top_en_i && m_pre == cmp0_i) ? 15'd0 : m_pre + 1;
            if (stop_i)       m_run = 0;
            else if (start_i) m_run = 1;
        end
    end

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cmp_all();
        chk("R2 running", {31'd0, running_o}, {31'd0, m_run});
        chk("R3 pre", {17'd0, pre_cnt_o}, {17'd0, m_pre});
        chk("R5 main", main_cnt_o, m_main);
        chk("R10 tick", {31'd0, tick_o}, {31'd0, m_tick});
        chk("R9 ovf", {31'd0, ovf_o}, {31'd0, m_ovf});
        chk("R12 combo", combo_o, {m_main[16:0], m_pre});
    endtask

    task automatic step();
        @(negedge clk);
        cmp_all();
        start_i = 0; stop_i = 0; pre_wr_i = 0; main_wr_i = 0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk("R1 pre", {17'd0, pre_cnt_o}, 32'd0);
        chk("R1 main", main_cnt_o, 32'd0);
        chk("R1 running", {31'd0, running_o}, 32'd0);
        chk("R1 pulses", {30'd0, tick_o, ovf_o}, 32'd0);

        // R2 stop wins when both strobes arrive from idle
        start_i = 1; stop_i = 1; step();
        chk("R2 both-from-idle", {31'd0, running_o}, 32'd0);
        // R3 divide by 1, run
        enable_i = 1; start_i = 1; step();
        chk("R2 started", {31'd0, running_o}, 32'd1);
        repeat (4) step();
        chk("R3 pre after 4", {17'd0, pre_cnt_o}, 32'd4);
        chk("R5 main k=0", main_cnt_o, 32'd4);
        // R9 natural wrap from all ones
        main_wr_i = 1; main_wdata_i = 32'hFFFF_FFFF; step();
        chk("R11 write", main_cnt_o, 32'hFFFF_FFFF);
        chk("R11 write no tick", {31'd0, tick_o}, 32'd0);
        step();
        chk("R9 wrap value", main_cnt_o, 32'd0);
        chk("R9 ovf pulse", {31'd0, ovf_o}, 32'd1);
        // R8 top wrap
        main_top_en_i = 1; cmp1_i = 32'd3;
        repeat (4) step();
        chk("R8 top wrap", main_cnt_o, 32'd0);
        chk("R8 ovf", {31'd0, ovf_o}, 32'd1);
        main_top_en_i = 0;
        // R5 divide by 8
        psc_sel_i = 3; pre_wr_i = 1; pre_wdata_i = 0; main_wr_i = 1; main_wdata_i = 0; step();
        repeat (24) step();
        chk("R5 div8", main_cnt_o, 32'd3);
        // R6 match mode + R7 pre top
        tick_mode_i = 1; pre_top_en_i = 1; cmp0_i = 15'd4;
        pre_wr_i = 1; pre_wdata_i = 0; main_wr_i = 1; main_wdata_i = 0; step();
        repeat (10) step();
        chk("R7 pre wrapped", {17'd0, pre_cnt_o}, 32'd0);
        chk("R6 match ticks", main_cnt_o, 32'd2);
        // R4 debug freeze
        dbg_halt_i = 1; dbg_run_i = 0; repeat (5) step();
        chk("R4 frozen pre", {17'd0, pre_cnt_o}, 32'd0);
        dbg_run_i = 1; repeat (2) step();
        chk("R4 debug run", {17'd0, pre_cnt_o}, 32'd2);
        dbg_halt_i = 0;
        // R2 stop wins while running
        start_i = 1; stop_i = 1; step();
        chk("R2 both-from-run", {31'd0, running_o}, 32'd0);

        // Constrained random phase
        for (int i = 0; i < 30000; i++) begin
            int r;
            if (i % 400 == 0) begin
                tick_mode_i   = $urandom % 2;
                psc_sel_i     = 4'($urandom % 5);
                pre_top_en_i  = $urandom % 2;
                main_top_en_i = $urandom % 2;
                cmp0_i        = 15'($urandom % 64);
                cmp1_i        = 32'($urandom % 40);
                dbg_run_i     = $urandom % 2;
            end
            r = $urandom % 100;
            start_i    = (r < 4) || (r == 6);
            stop_i     = (r == 5) || (r == 6);
            enable_i   = ($urandom % 16) != 0;
            dbg_halt_i = ($urandom % 8) == 0;
            if ($urandom % 150 == 0) begin
                pre_wr_i = 1; pre_wdata_i = 15'($urandom % 64);
            end
            if ($urandom % 250 == 0) begin
                main_wr_i = 1;
                main_wdata_i = ($urandom % 2) ? 32'hFFFF_FFF0 + 32'($urandom % 16)
                                              : 32'($urandom % 48);
            end
            @(negedge clk);
            cmp_all();
            start_i = 0; stop_i = 0; pre_wr_i = 0; main_wr_i = 0;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule